// File: doc/BRIEF.md
# Timer Compare Match Unit

This block pairs a free-running timer with a compare register and a small mode field. The timer advances by one on every cycle where the tick enable is high. Whenever the timer value arrives at equality with the compare register, a match event fires once. Depending on the selected mode, that event sets, clears or toggles a compare output. It may instead raise only an interrupt flag, or issue a special event trigger.

The special event trigger pulses an ADC start strobe in the match cycle itself. The timer returns to zero on the next tick rather than at once. The timer therefore visits every value from zero up to the compare value, and the compare register acts as an inclusive period register. Rewriting the compare value before that tick cancels the pending return to zero. Software reaches the compare value and the mode through a single write port with a one-bit register select.

Top module: `tcmp_unit`

## Requirements
- R1: After reset the timer, compare value, mode, compare output, interrupt flag and overflow flag are all zero. The timer adds one at each clock edge where `tickEn` is high and holds its value otherwise.
- R2: A write with `wrSel`=0 loads the compare value from `wrData`. A write with `wrSel`=1 loads the mode from `wrData[3:0]`. A match event fires once, in the first cycle in which the timer equals the compare value. It sets `irqFlag` when the mode is 4'b0010, 4'b1000, 4'b1001, 4'b1010 or 4'b1011. With any other mode code it sets nothing, and holding equality does not fire the event again.
- R3: On a match event, mode 4'b1000 sets `cmpOut`, mode 4'b1001 clears it and mode 4'b0010 inverts it. `cmpOutEn` is high exactly while the mode is one of these three codes.
- R4: In mode 4'b1010 a match event sets only the interrupt flag. `cmpOut` keeps its value and `cmpOutEn` stays low.
- R5: In mode 4'b1011, `adcStart` is high for exactly one clock, in the match cycle, when `adcEnable` is high. It stays low when `adcEnable` is low.
- R6: In mode 4'b1011 the timer keeps the compare value until the next tick after the match, and that tick loads zero. With ticks on every cycle the count runs 0 to the compare value, which gives a period of the compare value plus one.
- R7: A tick that wraps the timer from all ones to zero sets `ovfFlag`. A return to zero caused by the special event does not set it. `ovfClear` clears the flag.
- R8: Writing mode 4'b0000 forces `cmpOut` low at the next edge.
- R9: A compare write in any cycle from the match cycle up to and including the tick that would reset the timer cancels the reset. That tick then increments the timer instead.
- R10: `irqClear` clears `irqFlag`. When a match event and `irqClear` fall in the same cycle, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Timer tick enable |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | 0 selects the compare value, 1 selects the mode |
| wrData | input | TMR_W | Write data (mode uses bits 3:0) |
| adcEnable | input | 1 | Permits the ADC start strobe |
| irqClear | input | 1 | Clears the interrupt flag |
| ovfClear | input | 1 | Clears the overflow flag |
| tmrValue | output | TMR_W | Current timer value |
| cmpOut | output | 1 | Compare output latch |
| cmpOutEn | output | 1 | High while the block drives the compare output |
| irqFlag | output | 1 | Compare interrupt flag |
| ovfFlag | output | 1 | Timer overflow flag |
| adcStart | output | 1 | One-clock ADC start strobe |

## Verification
The delicate collision is between a compare write and the tick that would carry out the deferred reset. The bench provokes it twice. Once it holds the tick enable high and writes a new compare value in the very cycle the timer reaches the old one. Once it writes in an idle cycle between the match and the next tick. In both runs the timer must read one past the old compare value, not zero. A second collision puts an interrupt clear in the same cycle as a match event, and the flag must read set afterwards.

// File: rtl/tcmp_pkg.sv
package tcmp_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_OFF     = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_TOGGLE  = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SET     = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR     = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_IRQ     = 4'b1010;
  localparam logic [MODE_W-1:0] MODE_SPECIAL = 4'b1011;

  // strobes from control to datapath
  typedef struct packed {
    logic tmrInc;
    logic tmrZero;
  } tmrStrobe_t;

  function automatic logic modeHasCompare(input logic [MODE_W-1:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR) ||
           (m == MODE_IRQ) || (m == MODE_SPECIAL);
  endfunction

  function automatic logic modeDrivesPin(input logic [MODE_W-1:0] m);
    return (m == MODE_TOGGLE) || (m == MODE_SET) || (m == MODE_CLR);
  endfunction

endpackage

// File: rtl/tcmp_datapath.sv
module tcmp_datapath
  import tcmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrStrobe_t       strb,
  input  logic             cmpWr,
  input  logic [TMR_W-1:0] cmpWrData,
  input  logic             ovfClear,
  output logic [TMR_W-1:0] tmrValue,
  output logic             cmpEq,
  output logic             ovfFlag
);

  localparam logic [TMR_W-1:0] TMR_MAX = {TMR_W{1'b1}};

  logic [TMR_W-1:0] tmrReg;
  logic [TMR_W-1:0] cmpReg;
  logic             ovfReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tmrReg <= '0;
    end else if (strb.tmrZero) begin
      tmrReg <= '0;
    end else if (strb.tmrInc) begin
      tmrReg <= tmrReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmpReg <= '0;
    end else if (cmpWr) begin
      cmpReg <= cmpWrData;
    end
  end

  // only a natural wrap sets the flag; set beats clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfReg <= 1'b0;
    end else if (strb.tmrInc && (tmrReg == TMR_MAX)) begin
      ovfReg <= 1'b1;
    end else if (ovfClear) begin
      ovfReg <= 1'b0;
    end
  end

  assign tmrValue = tmrReg;
  assign cmpEq    = (tmrReg == cmpReg);
  assign ovfFlag  = ovfReg;

endmodule

// File: rtl/tcmp_control.sv
module tcmp_control
  import tcmp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              cmpEq,
  input  logic              cmpWr,
  input  logic              modeWr,
  input  logic [MODE_W-1:0] modeWrData,
  input  logic              adcEnable,
  input  logic              irqClear,
  output tmrStrobe_t        strb,
  output logic [MODE_W-1:0] modeValue,
  output logic              cmpOut,
  output logic              cmpOutEn,
  output logic              irqFlag,
  output logic              adcStart
);

  logic [MODE_W-1:0] modeReg;
  logic              matchSeen;
  logic              pendReset;
  logic              outLatch;
  logic              irqReg;

  logic matchEvent;
  logic specialHit;
  logic resetDue;

  assign matchEvent = cmpEq && !matchSeen;
  assign specialHit = matchEvent && (modeReg == MODE_SPECIAL);
  assign resetDue   = pendReset || specialHit;

  always_comb begin
    strb.tmrZero = tickEn && resetDue && !cmpWr;
    strb.tmrInc  = tickEn && !strb.tmrZero;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= MODE_OFF;
    end else if (modeWr) begin
      modeReg <= modeWrData;
    end
  end

  // equality is acted upon only in the cycle it first appears
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchSeen <= 1'b0;
    end else begin
      matchSeen <= cmpEq;
    end
  end

  // deferred reset: consumed by a tick, cancelled by a compare write
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendReset <= 1'b0;
    end else if (cmpWr || tickEn) begin
      pendReset <= 1'b0;
    end else if (specialHit) begin
      pendReset <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outLatch <= 1'b0;
    end else if (modeWr && (modeWrData == MODE_OFF)) begin
      outLatch <= 1'b0;
    end else if (matchEvent) begin
      case (modeReg)
        MODE_SET:    outLatch <= 1'b1;
        MODE_CLR:    outLatch <= 1'b0;
        MODE_TOGGLE: outLatch <= !outLatch;
        default:     outLatch <= outLatch;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReg <= 1'b0;
    end else if (matchEvent && modeHasCompare(modeReg)) begin
      irqReg <= 1'b1;
    end else if (irqClear) begin
      irqReg <= 1'b0;
    end
  end

  assign modeValue = modeReg;
  assign cmpOut    = outLatch;
  assign cmpOutEn  = modeDrivesPin(modeReg);
  assign irqFlag   = irqReg;
  assign adcStart  = specialHit && adcEnable;

endmodule

// File: rtl/tcmp_unit.sv
module tcmp_unit
  import tcmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tickEn,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [TMR_W-1:0] wrData,
  input  logic             adcEnable,
  input  logic             irqClear,
  input  logic             ovfClear,
  output logic [TMR_W-1:0] tmrValue,
  output logic             cmpOut,
  output logic             cmpOutEn,
  output logic             irqFlag,
  output logic             ovfFlag,
  output logic             adcStart
);

  tmrStrobe_t        strb;
  logic              cmpEq;
  logic              cmpWr;
  logic              modeWr;
  logic [MODE_W-1:0] modeValue;

  assign cmpWr  = wrEn && !wrSel;
  assign modeWr = wrEn && wrSel;

  tcmp_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .tickEn     (tickEn),
    .cmpEq      (cmpEq),
    .cmpWr      (cmpWr),
    .modeWr     (modeWr),
    .modeWrData (wrData[MODE_W-1:0]),
    .adcEnable  (adcEnable),
    .irqClear   (irqClear),
    .strb       (strb),
    .modeValue  (modeValue),
    .cmpOut     (cmpOut),
    .cmpOutEn   (cmpOutEn),
    .irqFlag    (irqFlag),
    .adcStart   (adcStart)
  );

  tcmp_datapath #(.TMR_W(TMR_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cmpWr     (cmpWr),
    .cmpWrData (wrData),
    .ovfClear  (ovfClear),
    .tmrValue  (tmrValue),
    .cmpEq     (cmpEq),
    .ovfFlag   (ovfFlag)
  );

endmodule

// File: rtl/tcmp_unit_checker.sv
module tcmp_unit_checker
  import tcmp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic              wrEn,
  input logic              wrSel,
  input logic [TMR_W-1:0]  wrData,
  input logic              adcEnable,
  input logic              irqClear,
  input logic [TMR_W-1:0]  tmrValue,
  input logic              cmpOut,
  input logic              cmpOutEn,
  input logic              irqFlag,
  input logic              ovfFlag,
  input logic              adcStart,
  input tmrStrobe_t        strb,
  input logic              cmpEq,
  input logic [MODE_W-1:0] modeValue
);

  p_hold_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tickEn |=> $stable(tmrValue));

  p_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.tmrInc |=> tmrValue == TMR_W'($past(tmrValue) + 1'b1));

  p_irq_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpEq) && modeHasCompare(modeValue)) |=> irqFlag);

  p_pin_en_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmpOutEn |-> (modeValue == MODE_SET || modeValue == MODE_CLR ||
                  modeValue == MODE_TOGGLE));

  p_irq_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(cmpEq) && modeValue == MODE_IRQ && !(wrEn && wrSel))
      |=> $stable(cmpOut));

  p_adc_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |=> !adcStart);

  p_adc_gate_r5: assert property (@(posedge clk) disable iff (!rstN)
    adcStart |-> (adcEnable && modeValue == MODE_SPECIAL));

  p_special_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    (adcStart && tickEn && !(wrEn && !wrSel)) |=> tmrValue == '0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.tmrZero && !ovfFlag) |=> !ovfFlag);

  p_mode_off_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel && wrData[MODE_W-1:0] == MODE_OFF) |=> !cmpOut);

  p_cancel_r9: assert property (@(posedge clk) disable iff (!rstN)
    (tickEn && wrEn && !wrSel) |=> tmrValue == TMR_W'($past(tmrValue) + 1'b1));

  p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    (irqClear && !cmpEq) |=> !irqFlag);

endmodule

bind tcmp_unit tcmp_unit_checker #(.TMR_W(TMR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .tickEn    (tickEn),
  .wrEn      (wrEn),
  .wrSel     (wrSel),
  .wrData    (wrData),
  .adcEnable (adcEnable),
  .irqClear  (irqClear),
  .tmrValue  (tmrValue),
  .cmpOut    (cmpOut),
  .cmpOutEn  (cmpOutEn),
  .irqFlag   (irqFlag),
  .ovfFlag   (ovfFlag),
  .adcStart  (adcStart),
  .strb      (strb),
  .cmpEq     (cmpEq),
  .modeValue (modeValue)
);

// File: tb/tcmp_unit_test.sv
module tcmp_unit_test;

  localparam int TMR_W = 16;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             tickEn = 1'b0;
  logic             wrEn = 1'b0;
  logic             wrSel = 1'b0;
  logic [TMR_W-1:0] wrData = '0;
  logic             adcEnable = 1'b0;
  logic             irqClear = 1'b0;
  logic             ovfClear = 1'b0;
  logic [TMR_W-1:0] tmrValue;
  logic             cmpOut;
  logic             cmpOutEn;
  logic             irqFlag;
  logic             ovfFlag;
  logic             adcStart;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tcmp_unit #(.TMR_W(TMR_W)) uut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .adcEnable(adcEnable), .irqClear(irqClear),
    .ovfClear(ovfClear), .tmrValue(tmrValue), .cmpOut(cmpOut),
    .cmpOutEn(cmpOutEn), .irqFlag(irqFlag), .ovfFlag(ovfFlag),
    .adcStart(adcStart)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; adcEnable = 1'b0;
    irqClear = 1'b0; ovfClear = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic writeReg(input logic sel, input logic [TMR_W-1:0] data);
    wrSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    tickEn = 1'b1;
    repeat (n) @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseIrqClear();
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
  endtask

  task automatic testReset();
    doReset();
    check("R1 reset timer", tmrValue, 0);
    check("R1 reset cmpOut", cmpOut, 0);
    check("R1 reset cmpOutEn", cmpOutEn, 0);
    check("R1 reset irq", irqFlag, 0);
    check("R1 reset ovf", ovfFlag, 0);
    check("R1 reset adcStart", adcStart, 0);
    idle(3);
    check("R1 hold without tick", tmrValue, 0);
    ticks(5);
    check("R1 count five ticks", tmrValue, 5);
    idle(2);
    check("R1 hold after ticks", tmrValue, 5);
  endtask

  task automatic testSetClear();
    doReset();
    writeReg(1'b0, 16'd1);
    writeReg(1'b1, 16'b1000);
    check("R3 set mode drives pin", cmpOutEn, 1);
    check("R3 latch low before match", cmpOut, 0);
    ticks(1);
    idle(1);
    check("R3 set on match", cmpOut, 1);
    check("R2 irq on set match", irqFlag, 1);
    writeReg(1'b1, 16'b1001);
    writeReg(1'b0, 16'd3);
    ticks(2);
    idle(1);
    check("R3 clear on match", cmpOut, 0);
    check("R3 clear mode drives pin", cmpOutEn, 1);
  endtask

  task automatic testToggleIrq();
    doReset();
    writeReg(1'b0, 16'd2);
    writeReg(1'b1, 16'b0010);
    ticks(2);
    idle(1);
    check("R3 toggle to one", cmpOut, 1);
    check("R2 irq on toggle match", irqFlag, 1);
    writeReg(1'b0, 16'd4);
    ticks(2);            // timer now 4, match cycle
    irqClear = 1'b1;     // collides with the match event
    @(negedge clk);
    irqClear = 1'b0;
    check("R10 set wins over clear", irqFlag, 1);
    check("R3 toggle back to zero", cmpOut, 0);
    pulseIrqClear();
    check("R10 clear", irqFlag, 0);
    idle(3);
    check("R2 no refire while equal", irqFlag, 0);
    check("R3 no refire toggle", cmpOut, 0);
  endtask

  task automatic testIrqOnly();
    doReset();
    writeReg(1'b0, 16'd1);
    writeReg(1'b1, 16'b1000);
    ticks(1);
    idle(1);
    writeReg(1'b1, 16'b1010);
    check("R4 irq mode releases pin", cmpOutEn, 0);
    writeReg(1'b0, 16'd3);
    pulseIrqClear();
    check("R10 clear before irq-only match", irqFlag, 0);
    ticks(2);
    idle(1);
    check("R4 irq set", irqFlag, 1);
    check("R4 cmpOut unchanged", cmpOut, 1);
    doReset();
    writeReg(1'b0, 16'd2);
    writeReg(1'b1, 16'b0101);
    ticks(2);
    idle(1);
    check("R2 invalid mode no irq", irqFlag, 0);
    check("R2 invalid mode no pin", cmpOutEn, 0);
  endtask

  task automatic testSpecial();
    doReset();
    adcEnable = 1'b1;
    writeReg(1'b0, 16'd3);
    writeReg(1'b1, 16'b1011);
    check("R6 special releases pin", cmpOutEn, 0);
    tickEn = 1'b1;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      check("R6 period sequence", tmrValue, i % 4);
      check("R5 adc strobe at match", adcStart, ((i % 4) == 3) ? 1 : 0);
    end
    tickEn = 1'b0;
    check("R2 irq in special", irqFlag, 1);
    check("R7 no ovf on special", ovfFlag, 0);
    doReset();
    writeReg(1'b0, 16'd3);
    writeReg(1'b1, 16'b1011);
    ticks(3);
    check("R5 no strobe when disabled", adcStart, 0);
    idle(1);
    check("R2 irq without adc", irqFlag, 1);
    doReset();
    adcEnable = 1'b1;
    writeReg(1'b0, 16'd2);
    writeReg(1'b1, 16'b1011);
    ticks(2);
    check("R5 strobe with sparse ticks", adcStart, 1);
    idle(1);
    check("R5 strobe one clock", adcStart, 0);
    check("R6 timer waits for tick", tmrValue, 2);
    idle(1);
    check("R6 still waiting", tmrValue, 2);
    ticks(1);
    check("R6 reset on next tick", tmrValue, 0);
  endtask

  task automatic testCancel();
    doReset();
    writeReg(1'b0, 16'd3);
    writeReg(1'b1, 16'b1011);
    ticks(3);
    idle(1);
    writeReg(1'b0, 16'd10);
    ticks(1);
    check("R9 cancel in gap", tmrValue, 4);
    doReset();
    writeReg(1'b0, 16'd3);
    writeReg(1'b1, 16'b1011);
    tickEn = 1'b1;
    repeat (3) @(negedge clk);
    wrSel = 1'b0; wrData = 16'd10; wrEn = 1'b1;   // same cycle as reset tick
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    check("R9 cancel on reset tick", tmrValue, 4);
  endtask

  task automatic testModeOff();
    doReset();
    writeReg(1'b0, 16'd1);
    writeReg(1'b1, 16'b1000);
    ticks(1);
    idle(1);
    check("R8 precondition high", cmpOut, 1);
    writeReg(1'b1, 16'b0000);
    check("R8 mode zero forces low", cmpOut, 0);
  endtask

  task automatic testOverflow();
    doReset();
    ticks(65535);
    check("R7 at top", tmrValue, 16'hFFFF);
    check("R7 no ovf before wrap", ovfFlag, 0);
    ticks(1);
    check("R7 wrap to zero", tmrValue, 0);
    check("R7 ovf on wrap", ovfFlag, 1);
    ovfClear = 1'b1;
    @(negedge clk);
    ovfClear = 1'b0;
    check("R7 ovf clear", ovfFlag, 0);
    writeReg(1'b0, 16'hFFFF);
    writeReg(1'b1, 16'b1011);
    ticks(65535);
    check("R6 special at top", tmrValue, 16'hFFFF);
    ticks(1);
    check("R6 special wraps", tmrValue, 0);
    check("R7 no ovf on special reset", ovfFlag, 0);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    testReset();
    testSetClear();
    testToggleIrq();
    testIrqOnly();
    testSpecial();
    testCancel();
    testModeOff();
    testOverflow();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule